// File: doc/BRIEF.md
# Packed 4-bit Pixel Scan-Line Realigner

This block copies one scan line of 4-bit pixels from a stream of 32-bit source words to a stream of 32-bit destination words. The first pixel of the line can sit at one position in the first source word and at a different position in the first destination word. Inside each byte the even pixel is stored in the upper nibble and the odd pixel in the lower nibble. For that reason the block first converts every word into a linear pixel order, shifts in that order, and converts back before it emits a word.

For each line, a start pulse captures four values: the bit position of the first source pixel, the bit position of the first destination pixel, the bit position of the last destination pixel inside the last destination word, and the number of destination words touched minus one. Source words arrive over a valid/ready handshake. The block reads exactly as many source words as the line needs and passes them straight through to the destination handshake, with one earlier source word held in a register. Each destination word carries a per-nibble write enable, so pixels outside the copied span can be left unwritten in memory.

Top module: `nib_line_realign`

## Requirements
- R1: Pixel positions are given as the starting bit number of the pixel, always a multiple of 4. Linear pixel p of a word lives in bits 4*(p XOR 1)+3 down to 4*(p XOR 1). A bit position b therefore names linear pixel (b/4) XOR 1. `dst_nib_en[n]` covers bits 4n+3 down to 4n of `dst_data`.
- R2: A start pulse while idle captures the line values. `busy` is high from the next cycle until the cycle in which `done` is high. While idle, `dst_valid` and `src_ready` stay low.
- R3: A line produces exactly width+1 destination handshakes. `done` is high for exactly one cycle, the cycle after the last destination handshake.
- R4: Let s and d be the linear start indices of source and destination. Destination linear position 8j+k of word j receives the pixel at source linear position 8j+k-d+s. Source positions count on from pixel 0 of the first source word of the line.
- R5: In the first word, only pixels with linear index at or above the start index are enabled. In the last word, only pixels at or below the end index are enabled. Words in between enable all eight pixels. With width 0, both limits apply to the single word.
- R6: Nibbles whose write enable is low carry zero on `dst_data`.
- R7: A line reads exactly floor((s + 8*width + e - d)/8) + 1 source words, where e is the linear end index. No further source word is accepted before the next start.
- R8: While `dst_valid` is high and `dst_ready` is low, `dst_valid`, `dst_data` and `dst_nib_en` stay unchanged, and no source word is taken except during the one priming read.
- R9: A start pulse while busy is ignored. The running line completes with its captured values.
- R10: After reset the block is idle: `busy`, `done`, `dst_valid` and `src_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a line; accepted only while idle |
| src_start | input | 5 | Bit position of the first source pixel |
| dst_start | input | 5 | Bit position of the first destination pixel |
| dst_end | input | 5 | Bit position of the last destination pixel in the last word |
| dst_width | input | 8 | Destination words touched minus one |
| src_data | input | 32 | Source word |
| src_valid | input | 1 | Source word offered |
| src_ready | output | 1 | Source word taken this cycle when valid |
| dst_data | output | 32 | Destination word |
| dst_nib_en | output | 8 | Per-nibble write enables |
| dst_valid | output | 1 | Destination word offered |
| dst_ready | input | 1 | Destination accepts the word |
| busy | output | 1 | Line in progress |
| done | output | 1 | One-cycle pulse after the last destination word |

## Verification
The assertions take for granted that all position inputs are multiples of 4 and that, for a single-word line, the end index is not below the start index. Without these, a word with no enabled nibble could appear. The hold property also assumes that the source keeps `src_valid` and `src_data` steady until its word is taken, because a word that is being consumed passes combinationally to `dst_data`. The stimulus uses only legal positions and orders start and end correctly for width 0. Its source driver never drops or changes an offered word before the handshake, and the destination side throttles `dst_ready` freely.

// File: rtl/nlr_pkg.sv
package nlr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PRIME = 2'd1,
      ST_RUN   = 2'd2
   } nlr_state_e;

   // Physical slot of a linear pixel inside a word (pairs swapped per byte)
   function automatic int slot_of(input int lin);
      return lin ^ 1;
   endfunction

endpackage

// File: rtl/nlr_swap.sv
module nlr_swap #(
   parameter int N  = 8,
   parameter int EW = 4
) (
   input  logic [N*EW-1:0] din,
   output logic [N*EW-1:0] dout
);
   if (N % 2 != 0) begin : g_bad_n
      $error("nlr_swap: element count must be even");
   end

   for (genvar p = 0; p < N; p++) begin : g_el
      assign dout[EW*p +: EW] = din[EW*nlr_pkg::slot_of(p) +: EW];
   end
endmodule

// File: rtl/nlr_shift.sv
module nlr_shift #(
   parameter int NPIX  = 8,
   parameter int PIX_W = 4,
   localparam int IDX_W = $clog2(NPIX)
) (
   input  logic [NPIX-1:0][PIX_W-1:0] lo,
   input  logic [NPIX-1:0][PIX_W-1:0] hi,
   input  logic [IDX_W-1:0]           sh,
   output logic [NPIX-1:0][PIX_W-1:0] dout
);
   logic [2*NPIX-1:0][PIX_W-1:0] win;

   always_comb begin
      win = {hi, lo};
      for (int k = 0; k < NPIX; k++) begin
         dout[k] = win[k + int'(sh)];
      end
   end
endmodule

// File: rtl/nlr_mask.sv
module nlr_mask #(
   parameter int NPIX = 8,
   localparam int IDX_W = $clog2(NPIX)
) (
   input  logic             first,
   input  logic             last,
   input  logic [IDX_W-1:0] lo_idx,
   input  logic [IDX_W-1:0] hi_idx,
   output logic [NPIX-1:0]  en
);
   for (genvar k = 0; k < NPIX; k++) begin : g_en
      assign en[k] = (!first || (IDX_W'(k) >= lo_idx)) &&
                     (!last  || (IDX_W'(k) <= hi_idx));
   end
endmodule

// File: rtl/nlr_ctrl.sv
module nlr_ctrl #(
   parameter int WORD_W = 32,
   parameter int PIX_W  = 4,
   parameter int CNT_W  = 8,
   localparam int NPIX  = WORD_W / PIX_W,
   localparam int IDX_W = $clog2(NPIX),
   localparam int POS_W = $clog2(WORD_W),
   localparam int SUB_W = $clog2(PIX_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [POS_W-1:0] src_start,
   input  logic [POS_W-1:0] dst_start,
   input  logic [POS_W-1:0] dst_end,
   input  logic [CNT_W-1:0] dst_width,
   input  logic             src_valid,
   input  logic             dst_ready,
   output logic             busy,
   output logic             src_ready,
   output logic             dst_valid,
   output logic             done,
   output logic             capture,
   output logic             use_cur,
   output logic             first,
   output logic             last,
   output logic [IDX_W-1:0] sh,
   output logic [IDX_W-1:0] d_idx,
   output logic [IDX_W-1:0] e_idx
);
   import nlr_pkg::*;

   localparam int SUM_W = CNT_W + IDX_W + 2;

   nlr_state_e       state_q;
   logic [CNT_W-1:0] wcnt_q, wlast_q;
   logic [CNT_W:0]   src_last_q;
   logic             prime_q, done_q;
   logic [IDX_W-1:0] sh_q, d_q, e_q;

   logic [IDX_W-1:0] s_in, d_in, e_in;
   logic [SUM_W-1:0] span_sum;
   logic             accept, dst_hs;

   assign s_in = src_start[POS_W-1:SUB_W] ^ IDX_W'(1);
   assign d_in = dst_start[POS_W-1:SUB_W] ^ IDX_W'(1);
   assign e_in = dst_end[POS_W-1:SUB_W]   ^ IDX_W'(1);

   // s + NPIX*width + e + NPIX - d, kept non-negative
   assign span_sum = SUM_W'(s_in) + (SUM_W'(dst_width) << IDX_W) + SUM_W'(e_in)
                   + SUM_W'(NPIX) - SUM_W'(d_in);

   assign accept  = start && (state_q == ST_IDLE);
   assign use_cur = (state_q == ST_RUN) &&
                    (({1'b0, wcnt_q} + (CNT_W+1)'(prime_q)) <= src_last_q);

   always_comb begin
      src_ready = 1'b0;
      dst_valid = 1'b0;
      case (state_q)
         ST_PRIME: src_ready = 1'b1;
         ST_RUN: begin
            dst_valid = use_cur ? src_valid : 1'b1;
            src_ready = use_cur && dst_ready;
         end
         default: ;
      endcase
   end

   assign dst_hs  = dst_valid && dst_ready;
   assign capture = ((state_q == ST_PRIME) && src_valid) || (dst_hs && use_cur);
   assign first   = (wcnt_q == '0);
   assign last    = (wcnt_q == wlast_q);
   assign busy    = (state_q != ST_IDLE);
   assign done    = done_q;
   assign sh      = sh_q;
   assign d_idx   = d_q;
   assign e_idx   = e_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         wcnt_q     <= '0;
         wlast_q    <= '0;
         src_last_q <= '0;
         prime_q    <= 1'b0;
         done_q     <= 1'b0;
         sh_q       <= '0;
         d_q        <= '0;
         e_q        <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (accept) begin
               wcnt_q     <= '0;
               wlast_q    <= dst_width;
               d_q        <= d_in;
               e_q        <= e_in;
               sh_q       <= s_in - d_in;
               prime_q    <= (s_in >= d_in);
               src_last_q <= (CNT_W+1)'(span_sum >> IDX_W) - (CNT_W+1)'(1);
               state_q    <= (s_in >= d_in) ? ST_PRIME : ST_RUN;
            end
            ST_PRIME: if (src_valid) state_q <= ST_RUN;
            ST_RUN: if (dst_hs) begin
               if (last) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  wcnt_q <= wcnt_q + CNT_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R1: positions captured at start are whole pixel boundaries
   a_r1_pixel_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (src_start[SUB_W-1:0] == '0) && (dst_start[SUB_W-1:0] == '0) &&
                 (dst_end[SUB_W-1:0] == '0));

   // R9: a start pulse in the middle of a line leaves the line running
   a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !(dst_hs && last)) |=> busy);

endmodule

// File: rtl/nib_line_realign.sv
module nib_line_realign #(
   parameter int WORD_W = 32,
   parameter int PIX_W  = 4,
   parameter int CNT_W  = 8,
   localparam int NPIX  = WORD_W / PIX_W,
   localparam int IDX_W = $clog2(NPIX),
   localparam int POS_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [POS_W-1:0]  src_start,
   input  logic [POS_W-1:0]  dst_start,
   input  logic [POS_W-1:0]  dst_end,
   input  logic [CNT_W-1:0]  dst_width,
   input  logic [WORD_W-1:0] src_data,
   input  logic              src_valid,
   output logic              src_ready,
   output logic [WORD_W-1:0] dst_data,
   output logic [NPIX-1:0]   dst_nib_en,
   output logic              dst_valid,
   input  logic              dst_ready,
   output logic              busy,
   output logic              done
);
   if (PIX_W != 4) begin : g_bad_pix
      $error("nib_line_realign: only 4-bit pixels (two per byte) are supported");
   end
   if ((WORD_W < 16) || ((WORD_W & (WORD_W - 1)) != 0)) begin : g_bad_word
      $error("nib_line_realign: word width must be a power of two, at least 16");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("nib_line_realign: count width must be positive");
   end

   logic [NPIX-1:0][PIX_W-1:0] cur_lin, cur_use, prev_q, out_lin, out_msk;
   logic [NPIX-1:0]            en_lin;
   logic                       capture, use_cur, first, last;
   logic [IDX_W-1:0]           sh, d_idx, e_idx;

   nlr_ctrl #(.WORD_W(WORD_W), .PIX_W(PIX_W), .CNT_W(CNT_W)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_start(src_start), .dst_start(dst_start), .dst_end(dst_end),
      .dst_width(dst_width), .src_valid(src_valid), .dst_ready(dst_ready),
      .busy(busy), .src_ready(src_ready), .dst_valid(dst_valid), .done(done),
      .capture(capture), .use_cur(use_cur), .first(first), .last(last),
      .sh(sh), .d_idx(d_idx), .e_idx(e_idx)
   );

   nlr_swap #(.N(NPIX), .EW(PIX_W)) i_unpack (.din(src_data), .dout(cur_lin));

   assign cur_use = use_cur ? cur_lin : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prev_q <= '0;
      else if (capture) prev_q <= cur_lin;
   end

   nlr_shift #(.NPIX(NPIX), .PIX_W(PIX_W)) i_shift (
      .lo(prev_q), .hi(cur_use), .sh(sh), .dout(out_lin)
   );

   nlr_mask #(.NPIX(NPIX)) i_mask (
      .first(first), .last(last), .lo_idx(d_idx), .hi_idx(e_idx), .en(en_lin)
   );

   for (genvar k = 0; k < NPIX; k++) begin : g_zero
      assign out_msk[k] = en_lin[k] ? out_lin[k] : '0;
   end

   nlr_swap #(.N(NPIX), .EW(PIX_W)) i_pack   (.din(out_msk), .dout(dst_data));
   nlr_swap #(.N(NPIX), .EW(1))     i_enswap (.din(en_lin),  .dout(dst_nib_en));

   // R3: completion flag never lasts two cycles
   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: nothing offered or taken while idle
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!dst_valid && !src_ready));

   // R8: a stalled destination word is held unchanged
   a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && !dst_ready) |=>
         (dst_valid && $stable(dst_data) && $stable(dst_nib_en)));

   // R5: every offered word writes at least one pixel
   a_r5_some_enable: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid |-> (dst_nib_en != '0));

   // R7: a source word taken while the destination stalls is only the priming read
   a_r7_src_follows_dst: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ready && !dst_ready) |-> !dst_valid);

endmodule

// File: tb/test_nib_line_realign.sv
module test_nib_line_realign;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [4:0]  src_start = '0, dst_start = '0, dst_end = '0;
   logic [7:0]  dst_width = '0;
   logic [31:0] src_data = '0;
   logic        src_valid = 1'b0;
   logic        src_ready;
   logic [31:0] dst_data;
   logic [7:0]  dst_nib_en;
   logic        dst_valid;
   logic        dst_ready = 1'b0;
   logic        busy, done;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   nib_line_realign i_nib_line_realign (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_start(src_start), .dst_start(dst_start), .dst_end(dst_end),
      .dst_width(dst_width), .src_data(src_data), .src_valid(src_valid),
      .src_ready(src_ready), .dst_data(dst_data), .dst_nib_en(dst_nib_en),
      .dst_valid(dst_valid), .dst_ready(dst_ready), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         mismatched++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   task automatic run_line(input int sb, input int db, input int eb, input int w,
                           input bit gaps, input bit bp, input bit inj);
      int s, d, e, nsrc, outn, consumed, cyc;
      bit done_next, fin, sv_hold, stalled;
      logic [31:0] srcw[$];
      logic [31:0] srcq[$];
      logic [31:0] expw[$];
      logic [7:0]  expen[$];
      logic [31:0] held_d;
      logic [7:0]  held_e;
      s = (sb / 4) ^ 1;
      d = (db / 4) ^ 1;
      e = (eb / 4) ^ 1;
      nsrc = ((s + 8*w + e - d) >> 3) + 1;
      for (int i = 0; i < nsrc; i++) srcw.push_back($urandom);
      // reference words from the linear pixel rule
      for (int j = 0; j <= w; j++) begin
         logic [31:0] ww;
         logic [7:0]  ee;
         ww = '0;
         ee = '0;
         for (int k = 0; k < 8; k++) begin
            int pos, sp;
            pos = 8*j + k;
            if (pos >= d && pos <= 8*w + e) begin
               sp = pos - d + s;
               ww[4*(k^1) +: 4] = srcw[sp/8][4*((sp%8)^1) +: 4];
               ee[k^1] = 1'b1;
            end
         end
         expw.push_back(ww);
         expen.push_back(ee);
      end
      srcq = srcw;
      srcq.push_back(32'hDEAD_BEEF);   // guard word: must not be taken

      @(negedge clk);
      start = 1'b1;
      src_start = 5'(sb); dst_start = 5'(db); dst_end = 5'(eb); dst_width = 8'(w);
      src_valid = 1'b0; dst_ready = 1'b0;
      @(negedge clk);
      start = 1'b0;

      outn = 0; consumed = 0; cyc = 0;
      done_next = 0; fin = 0; sv_hold = 0; stalled = 0;
      held_d = '0; held_e = '0;
      while (!fin) begin
         if (cyc > 0) @(negedge clk);
         start = inj && (cyc == 2);
         if (start) begin
            src_start = 5'd0; dst_start = 5'd28; dst_end = 5'd4; dst_width = 8'd9;
         end
         if (!sv_hold) src_valid = (srcq.size() > 0) && (!gaps || ($urandom % 4 != 0));
         src_data  = (srcq.size() > 0) ? srcq[0] : '0;
         dst_ready = bp ? ($urandom % 3 != 0) : 1'b1;
         #1;
         chk(done == done_next, "R3 done pulse", 64'(done), 64'(done_next));
         chk(busy == !done_next, "R2 busy", 64'(busy), 64'(!done_next));
         if (stalled) begin
            chk(dst_valid && dst_data == held_d && dst_nib_en == held_e,
                "R8 stalled word held", {24'(dst_nib_en), dst_data}, {24'(held_e), held_d});
         end
         if (done_next) fin = 1;
         done_next = 0;
         if (src_valid && src_ready) begin
            void'(srcq.pop_front());
            consumed++;
            sv_hold = 0;
         end else begin
            sv_hold = src_valid;
         end
         stalled = dst_valid && !dst_ready;
         held_d = dst_data;
         held_e = dst_nib_en;
         if (dst_valid && dst_ready) begin
            if (outn <= w) begin
               chk(dst_nib_en == expen[outn], "R1 R5 nibble enables",
                   64'(dst_nib_en), 64'(expen[outn]));
               chk(dst_data == expw[outn], "R4 R6 word data",
                   64'(dst_data), 64'(expw[outn]));
            end
            outn++;
            if (outn == w + 1) done_next = 1;
         end
         cyc++;
         if (cyc > 4000) begin
            chk(1'b0, "R3 line hung", 64'(outn), 64'(w + 1));
            fin = 1;
         end
      end
      src_valid = 1'b0;
      dst_ready = 1'b0;
      chk(outn == w + 1, "R3 R9 word count", 64'(outn), 64'(w + 1));
      chk(consumed == nsrc, "R7 source words read", 64'(consumed), 64'(nsrc));
      chk(srcq.size() == 1, "R7 guard untouched", 64'(srcq.size()), 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(!busy && !done && !dst_valid && !src_ready, "R10 reset state",
          {60'd0, busy, done, dst_valid, src_ready}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!busy && !dst_valid && !src_ready, "R2 idle after reset",
          {61'd0, busy, dst_valid, src_ready}, 64'd0);

      // start bit 4, destination bit 20, end bit 8, two words
      run_line(4, 20, 8, 1, 0, 0, 0);
      // aligned start, three words, with throttling
      run_line(12, 12, 0, 2, 1, 1, 0);
      // largest forward offset
      run_line(24, 4, 28, 3, 1, 0, 0);
      // largest backward offset under backpressure
      run_line(4, 24, 0, 2, 0, 1, 0);
      // single word, single pixel
      run_line(16, 8, 8, 0, 0, 0, 0);
      // single word, all pixels
      run_line(20, 4, 24, 0, 1, 1, 0);
      // long line
      run_line(8, 16, 12, 20, 1, 1, 0);
      // start pulse while busy is ignored (R9)
      run_line(0, 28, 20, 4, 0, 0, 1);
      run_line(28, 0, 4, 5, 1, 1, 1);
      // back-to-back lines
      run_line(0, 0, 0, 3, 0, 0, 0);
      run_line(20, 12, 16, 6, 1, 1, 0);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule